// File: doc/BRIEF.md
# Shared Sense-Amp Bank Tracker

This block keeps the open/closed state of the banks of a DRAM device in which neighbouring banks share sense-amplifier halves. Decoded commands arrive one at a time: activate, row precharge, read, write, read or write with auto-precharge, and an extended-operation precharge. For each command the block decides whether it is legal against the banks that are currently open. It then updates its bank state and reports the verdict with an error code one cycle later.

The banks form two independent halves. Inside a half, bank b shares an amplifier with b-1 and with b+1. The first and last bank of each half have only one neighbour, so the two middle banks (15 and 16 with the default size) never conflict. There are three ways to close a bank: a row precharge, a column command with auto-precharge, and an extended precharge. The extended precharge is accepted only straight after a read, or straight after a write with no byte mask, to the same bank. A query port returns the open flag and the open row of any bank. A mask output shows all open banks at once.

The command input is a valid/ready port. `cmd_ready` is high in every cycle outside reset, so the only back-pressure is reset itself. A command counts as accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. Every accepted command other than the no-op produces exactly one response cycle. The response port has no ready and cannot be stalled.

Top module: `bank_guard`

## Requirements
- R1: A synchronous reset closes every bank: `open_mask` reads 0, `resp_valid` is 0 and `cmd_ready` is 0 while `rst` is high.
- R2: An activate (op 1) to a closed bank whose neighbours are closed is legal: it sets that bank's bit in `open_mask`, and the query port then reports the bank open with the row given in `cmd_row`.
- R3: An activate to a bank whose neighbour in the same half is open is rejected with code 1. Bank b neighbours b-1 and b+1 only inside one half of NBANK/2 banks, so the last bank of the low half and the first bank of the high half never conflict.
- R4: An activate to a bank that is already open is rejected with code 2.
- R5: A read (op 3), write (op 4), read with auto-precharge (op 5) or write with auto-precharge (op 6) to a closed bank is rejected with code 3.
- R6: A row precharge (op 2) is always legal. It closes the bank, and a closed bank then reports row 0 on the query port. On an already closed bank it changes nothing.
- R7: A read or write with auto-precharge to an open bank is legal and leaves the bank closed.
- R8: An extended precharge (op 7) is legal only when the last legal non-no-op command was a read, or a write with `cmd_mask` = 0, to the same bank. Otherwise it is rejected with code 4. When legal, it closes the bank.
- R9: A rejected command leaves every bank's state, every stored row and the extended-precharge permission unchanged. It raises `resp_err` in its own response cycle only.
- R10: Each accepted command with op other than 0 (no-op) gives `resp_valid` high in the cycle after acceptance, with `resp_err` = 0 and code 0 when legal. A no-op gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted (low only in reset) |
| cmd_op | input | 3 | Operation code 0..7 |
| cmd_bank | input | BANK_W (5) | Target bank |
| cmd_row | input | ROW_W (10) | Row address for activate |
| cmd_mask | input | 1 | Write carries a byte mask |
| resp_valid | output | 1 | Verdict for the command accepted last cycle |
| resp_err | output | 1 | That command was illegal |
| resp_code | output | 3 | 0 ok, 1 neighbour open, 2 already open, 3 bank closed, 4 extended precharge not allowed |
| open_mask | output | NBANK (32) | One bit per bank, 1 = open |
| qry_bank | input | BANK_W (5) | Bank to inspect |
| qry_open | output | 1 | Inspected bank is open |
| qry_row | output | ROW_W (10) | Open row of the inspected bank, 0 when closed |

## Verification
The bench builds the block with its defaults: 32 banks and 10-bit rows. This puts the split between banks 15 and 16 within reach, together with the single-neighbour banks 0 and 31 at the outer edges. Rows such as 0x155 and 0x3FF exercise the full row width on the query port. The directed scenarios cover the edge of each half and every one of the three closing paths. They also cover the permission for the extended precharge as it is set, blocked by a masked write, and lost to an intervening command.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ACT    = 3'd1,
    OP_PRE    = 3'd2,
    OP_RD     = 3'd3,
    OP_WR     = 3'd4,
    OP_RD_AP  = 3'd5,
    OP_WR_AP  = 3'd6,
    OP_PRE_X  = 3'd7
  } cmd_op_e;

  typedef enum logic [2:0] {
    E_NONE      = 3'd0,
    E_NEIGHBOUR = 3'd1,
    E_IS_OPEN   = 3'd2,
    E_CLOSED    = 3'd3,
    E_NO_ARM    = 3'd4
  } err_code_e;

endpackage

// File: rtl/bt_adjacency.sv
module bt_adjacency #(
  parameter int NBANK = 32
) (
  input  logic [NBANK-1:0] open_i,
  output logic [NBANK-1:0] busy_nbr_o
);
  localparam int HALF = NBANK / 2;

  // A bank is blocked when a neighbour in its own half is open.
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic lo_busy;
    logic hi_busy;
    if ((b % HALF) != 0) begin : g_lo
      assign lo_busy = open_i[b-1];
    end else begin : g_lo_edge
      assign lo_busy = 1'b0;
    end
    if ((b % HALF) != HALF - 1) begin : g_hi
      assign hi_busy = open_i[b+1];
    end else begin : g_hi_edge
      assign hi_busy = 1'b0;
    end
    assign busy_nbr_o[b] = lo_busy | hi_busy;
  end

endmodule

// File: rtl/bt_bank_state.sv
module bt_bank_state #(
  parameter int NBANK = 32,
  parameter int ROW_W = 10,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [BANK_W-1:0] qry_bank,
  output logic [NBANK-1:0]  open_o,
  output logic [ROW_W-1:0]  qry_row
);
  localparam int HALF = NBANK / 2;

  logic [NBANK-1:0] open_q;
  logic [ROW_W-1:0] rows_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = (bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        open_q[b] <= 1'b0;
        rows_q[b] <= '0;
      end else if (set_en && hit) begin
        open_q[b] <= 1'b1;
        rows_q[b] <= row;
      end else if (clr_en && hit) begin
        open_q[b] <= 1'b0;
        rows_q[b] <= '0;
      end
    end

    // R3: two banks sharing an amplifier are never open together
    if ((b % HALF) != HALF - 1) begin : g_pair
      a_r3_no_shared_open: assert property (@(posedge clk) disable iff (rst)
        !(open_q[b] && open_q[b+1]));
    end

    // R9: an open bank nobody touches keeps its row
    a_r9_row_kept: assert property (@(posedge clk) disable iff (rst)
      (open_q[b] && !((set_en || clr_en) && hit)) |=> $stable(rows_q[b]));
  end

  // R2: open and close never requested together
  a_r2_single_update: assert property (@(posedge clk) disable iff (rst)
    !(set_en && clr_en));

  assign open_o  = open_q;
  assign qry_row = rows_q[qry_bank];

endmodule

// File: rtl/bt_verdict.sv
module bt_verdict
  import bt_pkg::*;
#(
  parameter int NBANK = 32,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  cmd_op_e           op,
  input  logic [BANK_W-1:0] bank,
  input  logic              mask,
  input  logic              bank_open,
  input  logic              nbr_busy,
  input  logic              arm_valid,
  input  logic [BANK_W-1:0] arm_bank,
  output err_code_e         code,
  output logic              do_open,
  output logic              do_close,
  output logic              arm_set
);

  always_comb begin
    code     = E_NONE;
    do_open  = 1'b0;
    do_close = 1'b0;
    arm_set  = 1'b0;
    unique case (op)
      OP_NOP: ;
      OP_ACT: begin
        if (bank_open)      code = E_IS_OPEN;
        else if (nbr_busy)  code = E_NEIGHBOUR;
        else                do_open = 1'b1;
      end
      OP_PRE: do_close = 1'b1;
      OP_RD: begin
        if (!bank_open) code = E_CLOSED;
        else            arm_set = 1'b1;
      end
      OP_WR: begin
        if (!bank_open) code = E_CLOSED;
        else            arm_set = !mask;
      end
      OP_RD_AP, OP_WR_AP: begin
        if (!bank_open) code = E_CLOSED;
        else            do_close = 1'b1;
      end
      OP_PRE_X: begin
        if (!(arm_valid && arm_bank == bank)) code = E_NO_ARM;
        else                                  do_close = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bank_guard.sv
module bank_guard
  import bt_pkg::*;
#(
  parameter int NBANK = 32,
  parameter int ROW_W = 10,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic              cmd_mask,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [2:0]        resp_code,
  output logic [NBANK-1:0]  open_mask,
  input  logic [BANK_W-1:0] qry_bank,
  output logic              qry_open,
  output logic [ROW_W-1:0]  qry_row
);

  cmd_op_e           op;
  logic              fire;
  logic              legal;
  logic [NBANK-1:0]  open_q;
  logic [NBANK-1:0]  busy_nbr;
  err_code_e         code;
  logic              do_open, do_close, arm_set;
  logic              arm_valid_q;
  logic [BANK_W-1:0] arm_bank_q;

  assign op        = cmd_op_e'(cmd_op);
  assign cmd_ready = !rst;
  assign fire      = cmd_valid && cmd_ready && (op != OP_NOP);
  assign legal     = (code == E_NONE);

  bt_adjacency #(.NBANK(NBANK)) u_adj (
    .open_i     (open_q),
    .busy_nbr_o (busy_nbr)
  );

  bt_verdict #(.NBANK(NBANK)) u_verdict (
    .op        (op),
    .bank      (cmd_bank),
    .mask      (cmd_mask),
    .bank_open (open_q[cmd_bank]),
    .nbr_busy  (busy_nbr[cmd_bank]),
    .arm_valid (arm_valid_q),
    .arm_bank  (arm_bank_q),
    .code      (code),
    .do_open   (do_open),
    .do_close  (do_close),
    .arm_set   (arm_set)
  );

  bt_bank_state #(.NBANK(NBANK), .ROW_W(ROW_W)) u_state (
    .clk      (clk),
    .rst      (rst),
    .set_en   (fire && legal && do_open),
    .clr_en   (fire && legal && do_close),
    .bank     (cmd_bank),
    .row      (cmd_row),
    .qry_bank (qry_bank),
    .open_o   (open_q),
    .qry_row  (qry_row)
  );

  // Extended-precharge permission: set by a legal read/unmasked write,
  // dropped by any other legal command, untouched by illegal ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      arm_valid_q <= 1'b0;
      arm_bank_q  <= '0;
    end else if (fire && legal) begin
      arm_valid_q <= arm_set;
      arm_bank_q  <= cmd_bank;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_code  <= E_NONE;
    end else begin
      resp_valid <= fire;
      resp_err   <= fire && !legal;
      resp_code  <= fire ? code : E_NONE;
    end
  end

  assign open_mask = open_q;
  assign qry_open  = open_q[qry_bank];

  // R1: leaving reset, every bank is closed
  a_r1_reset_closed: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (open_q == '0));

  // R4: activate to an open bank is refused
  a_r4_act_open_refused: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_ACT && open_q[cmd_bank]) |=> (resp_err && resp_code == E_IS_OPEN));

  // R7: after an auto-precharge column command the bank is closed
  a_r7_autopre_closed: assert property (@(posedge clk) disable iff (rst)
    (fire && (op == OP_RD_AP || op == OP_WR_AP)) |=> !open_q[$past(cmd_bank)]);

  // R9: a refused command leaves the open set as it was
  a_r9_err_keeps_state: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> (open_q == $past(open_q)));

  // R10: an error is only reported inside a response
  a_r10_err_in_resp: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> resp_valid);

endmodule

// File: tb/bank_guard_bench.sv
module bank_guard_bench;
  localparam int NB = 32;
  localparam int RW = 10;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, PRE = 3'd2, RD = 3'd3,
                         WR = 3'd4, RDA = 3'd5, WRA = 3'd6, PREX = 3'd7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic [4:0]    cmd_bank = '0;
  logic [RW-1:0] cmd_row = '0;
  logic          cmd_mask = 1'b0;
  logic          resp_valid, resp_err;
  logic [2:0]    resp_code;
  logic [NB-1:0] open_mask;
  logic [4:0]    qry_bank = '0;
  logic          qry_open;
  logic [RW-1:0] qry_row;

  int checks = 0;
  int errors = 0;
  logic [NB-1:0] exp_mask = '0;

  always #5 clk = ~clk;

  bank_guard #(.NBANK(NB), .ROW_W(RW)) u_bank_guard (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_mask(cmd_mask),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_code(resp_code),
    .open_mask(open_mask), .qry_bank(qry_bank), .qry_open(qry_open), .qry_row(qry_row)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Sends one command for one edge, then checks its response.
  task automatic issue(input string tag, input logic [2:0] op, input int bank,
                       input logic [RW-1:0] row, input logic msk,
                       input logic [2:0] exp_code);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bank = bank[4:0]; cmd_row = row; cmd_mask = msk;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = NOP;
    check({tag, " resp_valid"}, {31'd0, resp_valid}, 32'd1);
    check({tag, " resp_err"},   {31'd0, resp_err}, {31'd0, exp_code != 3'd0});
    check({tag, " resp_code"},  {29'd0, resp_code}, {29'd0, exp_code});
    check({tag, " open_mask"},  open_mask, exp_mask);
  endtask

  task automatic look(input string tag, input int bank, input logic o, input logic [RW-1:0] r);
    qry_bank = bank[4:0];
    #1;
    check({tag, " qry_open"}, {31'd0, qry_open}, {31'd0, o});
    check({tag, " qry_row"},  {22'd0, qry_row}, {22'd0, r});
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 ready in reset", {31'd0, cmd_ready}, 32'd0);
    check("R1 resp in reset", {31'd0, resp_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 mask after reset", open_mask, 32'd0);
    check("R10 ready after reset", {31'd0, cmd_ready}, 32'd1);
  endtask

  task automatic t_activate;
    exp_mask[3] = 1'b1;
    issue("R2 act b3", ACT, 3, 10'h155, 0, 3'd0);
    look("R2 query b3", 3, 1'b1, 10'h155);
    exp_mask[20] = 1'b1;
    issue("R2 act b20", ACT, 20, 10'h3FF, 0, 3'd0);
    look("R2 query b20", 20, 1'b1, 10'h3FF);
  endtask

  task automatic t_neighbour;
    issue("R3 act b4 beside b3", ACT, 4, 10'h1, 0, 3'd1);
    issue("R3 act b2 beside b3", ACT, 2, 10'h1, 0, 3'd1);
    exp_mask[15] = 1'b1;
    issue("R3 act b15", ACT, 15, 10'h0F, 0, 3'd0);
    exp_mask[16] = 1'b1;
    issue("R3 act b16 across split", ACT, 16, 10'h10, 0, 3'd0);
    issue("R3 act b14", ACT, 14, 10'h1, 0, 3'd1);
    issue("R3 act b17", ACT, 17, 10'h1, 0, 3'd1);
    exp_mask[0] = 1'b1;
    issue("R3 act b0", ACT, 0, 10'h2, 0, 3'd0);
    exp_mask[31] = 1'b1;
    issue("R3 act b31", ACT, 31, 10'h3, 0, 3'd0);
    issue("R3 act b1", ACT, 1, 10'h1, 0, 3'd1);
    issue("R3 act b30", ACT, 30, 10'h1, 0, 3'd1);
  endtask

  task automatic t_reopen;
    issue("R4 act open b3", ACT, 3, 10'h007, 0, 3'd2);
    look("R9 b3 row kept", 3, 1'b1, 10'h155);
  endtask

  task automatic t_closed;
    issue("R5 rd closed b5", RD, 5, 0, 0, 3'd3);
    issue("R5 wr closed b5", WR, 5, 0, 0, 3'd3);
    issue("R5 rda closed b5", RDA, 5, 0, 0, 3'd3);
    issue("R5 wra closed b5", WRA, 5, 0, 1, 3'd3);
  endtask

  task automatic t_precharge;
    exp_mask[3] = 1'b0;
    issue("R6 pre b3", PRE, 3, 0, 0, 3'd0);
    look("R6 b3 row cleared", 3, 1'b0, 10'h0);
    issue("R6 pre closed b3", PRE, 3, 0, 0, 3'd0);
    exp_mask[4] = 1'b1;
    issue("R6 act b4 after pre", ACT, 4, 10'h44, 0, 3'd0);
  endtask

  task automatic t_autopre;
    issue("R7 rd b4", RD, 4, 0, 0, 3'd0);
    exp_mask[4] = 1'b0;
    issue("R7 rda b4", RDA, 4, 0, 0, 3'd0);
    exp_mask[6] = 1'b1;
    issue("R7 act b6", ACT, 6, 10'h66, 0, 3'd0);
    exp_mask[6] = 1'b0;
    issue("R7 wra b6", WRA, 6, 0, 0, 3'd0);
    look("R7 b6 closed", 6, 1'b0, 10'h0);
  endtask

  task automatic t_extended;
    exp_mask[8] = 1'b1;
    issue("R8 act b8", ACT, 8, 10'h88, 0, 3'd0);
    issue("R8 rd b8", RD, 8, 0, 0, 3'd0);
    exp_mask[8] = 1'b0;
    issue("R8 prex after rd", PREX, 8, 0, 0, 3'd0);
    exp_mask[8] = 1'b1;
    issue("R8 act b8 again", ACT, 8, 10'h89, 0, 3'd0);
    issue("R8 masked wr b8", WR, 8, 0, 1, 3'd0);
    issue("R8 prex after masked wr", PREX, 8, 0, 0, 3'd4);
    issue("R8 unmasked wr b8", WR, 8, 0, 0, 3'd0);
    issue("R8 prex other bank", PREX, 10, 0, 0, 3'd4);
    exp_mask[8] = 1'b0;
    issue("R9 arm survives error", PREX, 8, 0, 0, 3'd0);
    exp_mask[8] = 1'b1;
    issue("R8 act b8 third", ACT, 8, 10'h8A, 0, 3'd0);
    issue("R8 rd b8 again", RD, 8, 0, 0, 3'd0);
    exp_mask[10] = 1'b1;
    issue("R8 act b10 between", ACT, 10, 10'hA, 0, 3'd0);
    issue("R8 prex arm lost", PREX, 8, 0, 0, 3'd4);
  endtask

  task automatic t_pulse_and_nop;
    issue("R9 error cmd", ACT, 9, 10'h1, 0, 3'd1);
    @(negedge clk);
    check("R9 err one cycle", {31'd0, resp_err}, 32'd0);
    check("R10 no resp idle", {31'd0, resp_valid}, 32'd0);
    cmd_valid = 1'b1; cmd_op = NOP; cmd_bank = 5'd12;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10 nop no resp", {31'd0, resp_valid}, 32'd0);
    check("R10 nop mask", open_mask, exp_mask);
  endtask

  task automatic t_reset_again;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 ready low mid reset", {31'd0, cmd_ready}, 32'd0);
    check("R1 mask cleared", open_mask, 32'd0);
    rst = 1'b0;
    exp_mask = '0;
    exp_mask[9] = 1'b1;
    issue("R1 act b9 after reset", ACT, 9, 10'h9, 0, 3'd0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R10 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_activate();
    t_neighbour();
    t_reopen();
    t_closed();
    t_precharge();
    t_autopre();
    t_extended();
    t_pulse_and_nop();
    t_reset_again();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule